// File: doc/BRIEF.md
# Parallel Flash Burst Read Controller

This block reads a run of consecutive words from one of several parallel NOR-type flash devices. It uses the synchronous burst protocol. The host presents a device select, a start address, a word count and a first-access latency, and pulses `req_valid` while the block is idle. The block then takes the flash bus and drives the address with an active-low address-valid strobe. It runs a flash clock derived from the system clock and returns each word with a one-cycle `rd_valid` pulse. When the burst is done it releases the bus.

The flash clock runs at half the system clock when `CLK_QUARTER` is 0, and at a quarter when it is 1. The quarter rate suits boards with two devices on a shared bus. An access flag `bus_req` tells an external arbiter that the flash bus is in use. When idle, the address pads are released through `fl_addr_oe`. The data pads are only ever inputs, because the block never writes.

Top module: `flash_burst_rd`

## Requirements
- R1: A request is accepted only when `busy` is low and `req_len` is nonzero. `busy` is high from the cycle after acceptance until the cycle after the bus is released, and is low at all other times.
- R2: `bus_req` rises together with `busy` and falls together with it. While any chip enable is low, `bus_req` is high.
- R3: With `CLK_QUARTER`=0, successive rising edges of `fl_clk` during a burst are exactly 2 system clocks apart.
- R4: With `CLK_QUARTER`=1, successive rising edges of `fl_clk` during a burst are exactly 4 system clocks apart.
- R5: In the first cycle after acceptance, `fl_adv_n` is low, `fl_addr_oe` is high and `fl_addr` equals the requested address. `fl_adv_n` returns high after the first `fl_clk` rising edge. The address holds steady while it is driven.
- R6: The first word is sampled at rising `fl_clk` edge number `req_lat`+1 counted after the address-latch edge. Each following word is sampled at the next rising edge.
- R7: Exactly `req_len` words are returned, in address order, one `rd_valid` pulse each, and only while `busy` is high.
- R8: Bit d of `fl_ce_n` goes low only for device d = `req_dev`, and only during an access. At most one chip enable is low at any time.
- R9: `fl_oe_n` is high in the address cycle and low only while a chip enable is low. `fl_we_n` is always high.
- R10: While idle, `fl_addr_oe` is low, all of `fl_ce_n` are high, `fl_oe_n` and `fl_adv_n` are high, and `fl_clk` is low.
- R11: A request with `req_len`=0, or any request made while `busy` is high, is ignored. It returns no words and leaves the burst in progress unchanged.
- R12: After reset, `busy`, `bus_req`, `rd_valid` and `fl_clk` are low, and all strobes are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, honoured only when idle |
| req_dev | input | DEV_W | Index of the device to read |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | CNT_W | Number of words, nonzero |
| req_lat | input | LAT_W | Flash clock edges between address latch and first data |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | DATA_W | Returned word |
| bus_req | output | 1 | Access flag toward the bus arbiter |
| fl_clk | output | 1 | Flash burst clock |
| fl_adv_n | output | 1 | Active-low address-valid strobe |
| fl_ce_n | output | NUM_DEV | Active-low chip enables, one per device |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_we_n | output | 1 | Active-low write enable, held high |
| fl_addr | output | ADDR_W | Flash address |
| fl_addr_oe | output | 1 | Pad drive enable for the address bus |
| fl_data_i | input | DATA_W | Flash data bus |

## Verification
The bench builds two instances. The main one uses a 16-bit data bus, 24-bit addresses, two devices and the half-rate clock. It can check device selection across both chip enables, address wrap at the top of the space, and latencies from 0 to 15 against a behavioural flash model. The second uses an 8-bit bus, one device and the quarter-rate clock. It checks the 4-cycle flash clock period and the byte-wide variant of the capture path.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADV,
      ST_LAT,
      ST_DATA,
      ST_END
   } fb_state_t;
endpackage

// File: rtl/fb_clkdiv.sv
module fb_clkdiv #(
   parameter bit CLK_QUARTER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic fl_clk,
   output logic rise_stb
);
   generate
      if (CLK_QUARTER) begin : g_quarter
         logic [1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase <= '0;
            else if (!run) phase <= '0;
            else           phase <= phase + 2'd1;
         end
         assign fl_clk   = phase[1];
         assign rise_stb = run && (phase == 2'b01);
      end else begin : g_half
         logic tog;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    tog <= 1'b0;
            else if (!run) tog <= 1'b0;
            else           tog <= ~tog;
         end
         assign fl_clk   = tog;
         assign rise_stb = run && !tog;
      end
   endgenerate
endmodule

// File: rtl/fb_capture.sv
module fb_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [DATA_W-1:0] din,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= sample;
         if (sample) rd_data <= din;
      end
   end
endmodule

// File: rtl/fb_seq.sv
module fb_seq
   import flash_burst_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int NUM_DEV = 2,
   parameter int CNT_W   = 8,
   parameter int LAT_W   = 4,
   parameter int DEV_W   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [DEV_W-1:0]   req_dev,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [CNT_W-1:0]   req_len,
   input  logic [LAT_W-1:0]   req_lat,
   input  logic               rise_stb,
   output logic               busy,
   output logic               bus_req,
   output logic               run,
   output logic               sample,
   output logic               adv_n,
   output logic               oe_n,
   output logic               addr_oe,
   output logic [ADDR_W-1:0]  addr_q,
   output logic [NUM_DEV-1:0] ce_n
);
   fb_state_t         state;
   logic [DEV_W-1:0]  dev_q;
   logic [CNT_W-1:0]  words_left;
   logic [LAT_W-1:0]  lat_left;
   logic              on_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         dev_q      <= '0;
         addr_q     <= '0;
         words_left <= '0;
         lat_left   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid && (req_len != '0)) begin
               state      <= ST_ADV;
               dev_q      <= req_dev;
               addr_q     <= req_addr;
               words_left <= req_len;
               lat_left   <= req_lat;
            end
            ST_ADV: if (rise_stb) begin
               state <= (lat_left == '0) ? ST_DATA : ST_LAT;
            end
            ST_LAT: if (rise_stb) begin
               lat_left <= lat_left - 1'b1;
               if (lat_left == LAT_W'(1)) state <= ST_DATA;
            end
            ST_DATA: if (rise_stb) begin
               words_left <= words_left - 1'b1;
               if (words_left == CNT_W'(1)) state <= ST_END;
            end
            ST_END:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign on_bus  = (state == ST_ADV) || (state == ST_LAT) || (state == ST_DATA);
   assign busy    = (state != ST_IDLE);
   assign bus_req = (state != ST_IDLE);
   assign run     = on_bus;
   assign addr_oe = on_bus;
   assign adv_n   = (state != ST_ADV);
   assign oe_n    = !((state == ST_LAT) || (state == ST_DATA));
   assign sample  = (state == ST_DATA) && rise_stb;

   generate
      for (genvar d = 0; d < NUM_DEV; d++) begin : g_ce
         assign ce_n[d] = !(on_bus && (dev_q == DEV_W'(d)));
      end
   endgenerate
endmodule

// File: rtl/flash_burst_rd.sv
module flash_burst_rd #(
   parameter int  DATA_W      = 16,
   parameter int  ADDR_W      = 24,
   parameter int  NUM_DEV     = 2,
   parameter int  CNT_W       = 8,
   parameter int  LAT_W       = 4,
   parameter bit  CLK_QUARTER = 1'b0,
   localparam int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [DEV_W-1:0]   req_dev,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [CNT_W-1:0]   req_len,
   input  logic [LAT_W-1:0]   req_lat,
   output logic               busy,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               bus_req,
   output logic               fl_clk,
   output logic               fl_adv_n,
   output logic [NUM_DEV-1:0] fl_ce_n,
   output logic               fl_oe_n,
   output logic               fl_we_n,
   output logic [ADDR_W-1:0]  fl_addr,
   output logic               fl_addr_oe,
   input  logic [DATA_W-1:0]  fl_data_i
);
   generate
      if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32)) begin : g_bad_data_w
         $error("flash_burst_rd: DATA_W must be 8, 16 or 32");
      end
      if (ADDR_W < 1 || NUM_DEV < 1 || CNT_W < 1 || LAT_W < 1) begin : g_bad_sizes
         $error("flash_burst_rd: widths and device count must be positive");
      end
   endgenerate

   logic clk_run;
   logic rise_stb;
   logic sample;

   fb_clkdiv #(.CLK_QUARTER(CLK_QUARTER)) u_clkdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (clk_run),
      .fl_clk   (fl_clk),
      .rise_stb (rise_stb)
   );

   fb_seq #(
      .ADDR_W  (ADDR_W),
      .NUM_DEV (NUM_DEV),
      .CNT_W   (CNT_W),
      .LAT_W   (LAT_W),
      .DEV_W   (DEV_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_dev   (req_dev),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .req_lat   (req_lat),
      .rise_stb  (rise_stb),
      .busy      (busy),
      .bus_req   (bus_req),
      .run       (clk_run),
      .sample    (sample),
      .adv_n     (fl_adv_n),
      .oe_n      (fl_oe_n),
      .addr_oe   (fl_addr_oe),
      .addr_q    (fl_addr),
      .ce_n      (fl_ce_n)
   );

   fb_capture #(.DATA_W(DATA_W)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample   (sample),
      .din      (fl_data_i),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign fl_we_n = 1'b1;
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
   parameter int NUM_DEV     = 2,
   parameter int ADDR_W      = 24,
   parameter int CNT_W       = 8,
   parameter bit CLK_QUARTER = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [CNT_W-1:0]   req_len,
   input logic               busy,
   input logic               bus_req,
   input logic               rd_valid,
   input logic               fl_clk,
   input logic               fl_adv_n,
   input logic [NUM_DEV-1:0] fl_ce_n,
   input logic               fl_oe_n,
   input logic [ADDR_W-1:0]  fl_addr,
   input logic               fl_addr_oe,
   input logic               clk_run
);
   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_len != '0) |=> (busy && bus_req)); // R1
   AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_len == '0) |=> !busy); // R11
   AST_CE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_ce_n != '1) |-> bus_req); // R2
   AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~fl_ce_n)); // R8
   AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (fl_ce_n != '1)); // R9
   AST_ADV_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_adv_n |-> (fl_addr_oe && fl_oe_n)); // R5
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_addr_oe && $past(fl_addr_oe)) |-> $stable(fl_addr)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fl_addr_oe && fl_oe_n && fl_adv_n && !fl_clk && fl_ce_n == '1)); // R10
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy); // R7

   generate
      if (!CLK_QUARTER) begin : g_half_chk
         AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clk_run) |-> (fl_clk != $past(fl_clk))); // R3
      end
   endgenerate
endmodule

bind flash_burst_rd fb_checker #(
   .NUM_DEV     (NUM_DEV),
   .ADDR_W      (ADDR_W),
   .CNT_W       (CNT_W),
   .CLK_QUARTER (CLK_QUARTER)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_len    (req_len),
   .busy       (busy),
   .bus_req    (bus_req),
   .rd_valid   (rd_valid),
   .fl_clk     (fl_clk),
   .fl_adv_n   (fl_adv_n),
   .fl_ce_n    (fl_ce_n),
   .fl_oe_n    (fl_oe_n),
   .fl_addr    (fl_addr),
   .fl_addr_oe (fl_addr_oe),
   .clk_run    (clk_run)
);

// File: tb/flash_burst_rd_tb.sv
module flash_burst_rd_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // main instance: 16-bit data, 24-bit address, two devices, half rate
   logic        req_valid = 1'b0;
   logic [0:0]  req_dev = '0;
   logic [23:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic [3:0]  req_lat = '0;
   logic        busy, rd_valid, bus_req, fl_clk, fl_adv_n, fl_oe_n, fl_we_n, fl_addr_oe;
   logic [15:0] rd_data;
   logic [1:0]  fl_ce_n;
   logic [23:0] fl_addr;
   logic [15:0] fl_data_i;

   flash_burst_rd #(.DATA_W(16), .ADDR_W(24), .NUM_DEV(2), .CLK_QUARTER(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
      .req_addr(req_addr), .req_len(req_len), .req_lat(req_lat), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .bus_req(bus_req), .fl_clk(fl_clk),
      .fl_adv_n(fl_adv_n), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
      .fl_addr(fl_addr), .fl_addr_oe(fl_addr_oe), .fl_data_i(fl_data_i));

   // second instance: 8-bit data, one device, quarter rate
   logic        q_valid = 1'b0;
   logic        q_busy, q_rd_valid, q_bus_req, q_fl_clk, q_adv_n, q_oe_n, q_we_n, q_addr_oe;
   logic [7:0]  q_rd_data;
   logic [0:0]  q_ce_n;
   logic [15:0] q_addr;

   flash_burst_rd #(.DATA_W(8), .ADDR_W(16), .NUM_DEV(1), .CLK_QUARTER(1'b1)) u_dut_q (
      .clk(clk), .rst_n(rst_n), .req_valid(q_valid), .req_dev(1'b0),
      .req_addr(16'h0040), .req_len(8'd3), .req_lat(4'd1), .busy(q_busy),
      .rd_valid(q_rd_valid), .rd_data(q_rd_data), .bus_req(q_bus_req), .fl_clk(q_fl_clk),
      .fl_adv_n(q_adv_n), .fl_ce_n(q_ce_n), .fl_oe_n(q_oe_n), .fl_we_n(q_we_n),
      .fl_addr(q_addr), .fl_addr_oe(q_addr_oe), .fl_data_i(8'h9C));

   function automatic logic [15:0] pat(logic [23:0] a);
      return a[15:0] ^ {a[23:16], 8'h3C};
   endfunction

   // behavioural flash: latches on the address-valid edge, counts later edges
   int          cur_lat = 0;
   int          cur_dev = 0;
   logic        adv_s = 1'b1;
   logic [23:0] addr_s = '0;
   logic [23:0] m_addr = '0;
   int          e = 0;
   always @(negedge clk) begin
      adv_s  <= fl_adv_n;
      addr_s <= fl_addr;
   end
   always @(posedge fl_clk) begin
      if (!adv_s) begin
         m_addr <= addr_s;
         e      <= 0;
      end else begin
         e <= e + 1;
      end
   end
   assign fl_data_i = pat(m_addr + 24'(e - cur_lat));

   // monitors, all at the falling edge
   logic [15:0] got [256];
   int widx = 0, q_words = 0, q_bad_data = 0;
   int cyc = 0, last_rise = -1, q_last_rise = -1;
   bit ce_bad = 0, per_bad = 0, we_bad = 0, q_per_bad = 0;
   logic prev_clk = 1'b0, q_prev_clk = 1'b0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      prev_clk <= fl_clk;
      q_prev_clk <= q_fl_clk;
      if (rd_valid) begin
         got[widx[7:0]] = rd_data;
         widx = widx + 1;
      end
      if (q_rd_valid) begin
         q_words = q_words + 1;
         if (q_rd_data != 8'h9C) q_bad_data = q_bad_data + 1;
      end
      if (fl_ce_n != 2'b11 && fl_ce_n != ~(2'b01 << cur_dev)) ce_bad = 1;
      if (!fl_we_n || !q_we_n) we_bad = 1;
      if (fl_clk && !prev_clk) begin
         if (last_rise >= 0 && (cyc - last_rise) != 2) per_bad = 1;
         last_rise = cyc;
      end
      if (q_fl_clk && !q_prev_clk) begin
         if (q_last_rise >= 0 && (cyc - q_last_rise) != 4) q_per_bad = 1;
         q_last_rise = cyc;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic idle_ok(input string tag);
      chk(!busy && !bus_req, "R2", {tag, " busy/bus_req low"}, {busy, bus_req}, 0);
      chk(!fl_addr_oe && fl_ce_n == 2'b11 && fl_oe_n && fl_adv_n && !fl_clk, "R10",
          {tag, " idle pins"}, {fl_addr_oe, fl_ce_n, fl_oe_n, fl_adv_n, fl_clk}, 6'b011110);
   endtask

   task automatic run(input int dev, input logic [23:0] addr, input int len,
                      input int lat, input bit inject);
      int t;
      int bad;
      logic [15:0] ba, be;
      @(negedge clk);
      cur_lat = lat; cur_dev = dev; widx = 0; last_rise = -1;
      ce_bad = 0; per_bad = 0;
      req_dev = dev[0:0]; req_addr = addr; req_len = len[7:0]; req_lat = lat[3:0];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && bus_req, "R1", "busy and bus_req after accept", {busy, bus_req}, 2'b11);
      chk(!fl_adv_n && fl_addr_oe && fl_addr == addr, "R5", "address phase",
          {fl_adv_n, fl_addr_oe, fl_addr}, {2'b01, addr});
      chk(fl_oe_n, "R9", "oe high in address phase", fl_oe_n, 1);
      if (inject) begin
         repeat (3) @(negedge clk);
         req_addr = addr ^ 24'h001234; req_len = 8'd9; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(widx == len, "R7", "word count", widx, len);
      bad = 0; ba = '0; be = '0;
      for (int i = 0; i < len; i++) begin
         if (got[i] !== pat(addr + 24'(i))) begin
            if (bad == 0) begin ba = got[i]; be = pat(addr + 24'(i)); end
            bad++;
         end
      end
      chk(bad == 0, "R6", "burst data after latency", ba, be);
      chk(!ce_bad, "R8", "only selected chip enable low", ce_bad, 0);
      chk(!per_bad, "R3", "half-rate flash clock period", per_bad, 0);
      idle_ok("end of burst");
      if (inject) begin
         bad = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy || rd_valid) bad++;
         end
         chk(bad == 0, "R11", "request during busy ignored", bad, 0);
      end
   endtask

   localparam int NV = 6;
   localparam int V_DEV [NV] = '{0, 1, 0, 1, 0, 1};
   localparam logic [23:0] V_ADDR [NV] =
      '{24'h000100, 24'h00FFFE, 24'h123456, 24'hABCDEF, 24'h000000, 24'hFFFFFE};
   localparam int V_LEN [NV] = '{4, 5, 1, 8, 3, 4};
   localparam int V_LAT [NV] = '{2, 0, 3, 1, 15, 4};

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12: reset state
      chk(!busy && !bus_req && !rd_valid && !fl_clk, "R12", "reset outputs",
          {busy, bus_req, rd_valid, fl_clk}, 0);
      chk(fl_ce_n == 2'b11 && fl_oe_n && fl_we_n && fl_adv_n && !fl_addr_oe, "R12",
          "reset strobes", {fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, fl_addr_oe}, 6'b111110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) run(V_DEV[v], V_ADDR[v], V_LEN[v], V_LAT[v], 1'b0);

      // R11: zero-length request ignored
      req_len = 8'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      begin
         int bad = 0;
         for (int k = 0; k < 5; k++) begin
            if (busy || rd_valid || fl_addr_oe) bad++;
            @(negedge clk);
         end
         chk(bad == 0, "R11", "zero-length request ignored", bad, 0);
      end
      idle_ok("after zero length");

      // R11: second request while a burst runs
      run(1, 24'h00ABC0, 6, 2, 1'b1);

      // R4: quarter-rate instance
      q_valid = 1'b1;
      @(negedge clk);
      q_valid = 1'b0;
      chk(q_busy && q_bus_req && !q_adv_n, "R1", "quarter instance accepts",
          {q_busy, q_bus_req, q_adv_n}, 3'b110);
      begin
         int t = 0;
         while (q_busy && t < 5000) begin
            @(negedge clk);
            t++;
         end
      end
      chk(!q_per_bad && q_last_rise >= 0, "R4", "quarter-rate flash clock period",
          q_per_bad, 0);
      chk(q_words == 3 && q_bad_data == 0, "R7", "quarter instance word count",
          q_words, 3);
      chk(!q_bus_req && !q_addr_oe && q_ce_n == 1'b1 && !q_fl_clk, "R10",
          "quarter instance released", {q_bus_req, q_addr_oe, q_ce_n, q_fl_clk}, 4'b0010);
      chk(!we_bad, "R9", "write enable held high", we_bad, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule